// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between a serial-bus front end and a byte-wide non-volatile array. A write transaction opens with a start strobe that carries the full byte address. The upper bits of that address name a page, and the page stays fixed for the whole transaction. The lower bits give a starting offset inside the page. Each load strobe after that puts one byte into a page-sized staging buffer and marks that slot as filled. The in-page offset then advances, and it wraps at the page boundary. A later byte aimed at a filled slot replaces the byte already there.

A commit strobe ends the transaction. If any slot holds a byte, the block enters a timed write cycle. During that cycle it sends the filled slots to the array write port, one per clock, in rising offset order, and it keeps busy high for a programmable number of clock cycles. Start, load and commit strobes that arrive while the block is busy are dropped. After reset, the block first writes the erased value into every array location before it accepts any work.

Top module: `pwb_ctrl`

## Requirements
- R1: While reset is applied and after it is released, busy is high. Starting at the first clock edge after release, the block writes ERASED_VAL (all ones by default) to addresses 0, 1, 2 and onward up to the last address, one address per clock. Busy falls after the last of those writes.
- R2: An accepted start latches the page from wr_addr[ADDR_W-1:OFS_W] and the offset from wr_addr[OFS_W-1:0]. Every write that comes from one commit goes to that latched page.
- R3: The offset goes up by one after each accepted load and wraps from the last slot of the page back to slot 0.
- R4: A load to a slot that is already filled replaces the byte in it, and only the latest byte is written to the array.
- R5: On commit, each filled slot is written exactly once, one write per clock, with addresses strictly rising. Array locations with no loaded byte keep their contents.
- R6: A commit with at least one filled slot raises busy in the next cycle, and busy stays high for exactly WR_CYCLES cycles.
- R7: Start, load and commit strobes that arrive while busy is high have no effect. The array contents stay the same, and a later commit with no new start causes no writes.
- R8: An accepted start clears every filled mark, so bytes loaded before it are never written.
- R9: A commit with no filled slot leaves busy low, causes no writes, and closes the transaction.
- R10: Loads and commits that arrive when no transaction is open are ignored, and cause no writes and no busy.
- R11: mem_we is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_open | input | 1 | Start-of-write strobe |
| wr_addr | input | ADDR_W | Start address: page and in-page offset |
| ld_en | input | 1 | Byte-load strobe |
| ld_data | input | DATA_W | Byte to load |
| wr_commit | input | 1 | Commit (end of transaction) strobe |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Erase sweep or write cycle in progress |

## Verification
The bench builds the block with PAGE_W=4, OFS_W=6 and WR_CYCLES=80. The page keeps its full 64 slots, so wrap and overwrite behave exactly as they would at full size. With only 16 pages, the erase sweep takes 1024 cycles, and a whole-array comparison after every transaction stays cheap. A write cycle of 80 clocks still leaves room for a full 64-byte drain, and it is short enough that many random transactions fit in the run. Strobes injected during busy exercise the ignore rule.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    PWB_INIT  = 2'd0,
    PWB_IDLE  = 2'd1,
    PWB_WRITE = 2'd2
  } pwb_state_e;

  // next in-page offset, wrapping inside a page of 2**ofs_w slots
  function automatic logic [15:0] pwb_wrap_inc(input logic [15:0] ofs, input int unsigned ofs_w);
    logic [15:0] mask;
    mask = 16'((32'd1 << ofs_w) - 32'd1);
    return (ofs + 16'd1) & mask;
  endfunction

  // full array address from page number and in-page offset
  function automatic logic [31:0] pwb_join(input logic [31:0] page, input logic [31:0] ofs,
                                           input int unsigned ofs_w);
    return (page << ofs_w) | ofs;
  endfunction

endpackage

// File: rtl/pwb_pick.sv
module pwb_pick #(
  parameter int W     = 64,
  parameter int IDX_W = 6
) (
  input  logic [W-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwb_slots.sv
module pwb_slots #(
  parameter int SLOTS  = 64,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              drop,
  input  logic [IDX_W-1:0]  drop_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [SLOTS-1:0]  filled
);
  logic [SLOTS*DATA_W-1:0] flat;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic              v_q;
    logic [DATA_W-1:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        b_q <= '0;
      end else if (clr) begin
        v_q <= 1'b0;
      end else if (ld && ld_idx == IDX_W'(g)) begin
        v_q <= 1'b1;
        b_q <= ld_data;
      end else if (drop && drop_idx == IDX_W'(g)) begin
        v_q <= 1'b0;
      end
    end
    assign filled[g] = v_q;
    assign flat[g*DATA_W +: DATA_W] = b_q;
  end

  assign rd_data = flat[rd_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int CYCLES = 1250000,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= CNT_W'(CYCLES - 1);
    else if (run && !zero)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFS_W     = 6,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1250000,
  parameter logic [DATA_W-1:0] ERASED_VAL = '1,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              wr_commit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  localparam int SLOTS = 1 << OFS_W;

  pwb_state_e         state_q;
  logic               open_q;
  logic [PAGE_W-1:0]  page_q;
  logic [OFS_W-1:0]   ofs_q;
  logic [ADDR_W-1:0]  init_q;

  logic [SLOTS-1:0]   filled;
  logic               any_filled;
  logic [OFS_W-1:0]   pick_idx;
  logic [DATA_W-1:0]  pick_data;
  logic               tmr_zero;

  // named internal events
  logic idle_phase, init_phase, wr_phase;
  logic evt_open, evt_load, evt_commit, evt_commit_go, evt_commit_empty;
  logic drain_en, evt_release, init_last;

  assign idle_phase = (state_q == PWB_IDLE);
  assign init_phase = (state_q == PWB_INIT);
  assign wr_phase   = (state_q == PWB_WRITE);

  assign evt_open         = idle_phase && wr_open;
  assign evt_load         = idle_phase && open_q && !wr_open && ld_en;
  assign evt_commit       = idle_phase && open_q && !wr_open && !ld_en && wr_commit;
  assign evt_commit_go    = evt_commit && any_filled;
  assign evt_commit_empty = evt_commit && !any_filled;
  assign drain_en         = wr_phase && any_filled;
  assign evt_release      = wr_phase && tmr_zero && !any_filled;
  assign init_last        = init_phase && (init_q == '1);

  pwb_slots #(.SLOTS(SLOTS), .IDX_W(OFS_W), .DATA_W(DATA_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (evt_open),
    .ld       (evt_load),
    .ld_idx   (ofs_q),
    .ld_data  (ld_data),
    .drop     (drain_en),
    .drop_idx (pick_idx),
    .rd_idx   (pick_idx),
    .rd_data  (pick_data),
    .filled   (filled)
  );

  pwb_pick #(.W(SLOTS), .IDX_W(OFS_W)) u_pick (
    .req   (filled),
    .idx   (pick_idx),
    .found (any_filled)
  );

  pwb_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (evt_commit_go),
    .run   (wr_phase),
    .zero  (tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWB_INIT;
      init_q  <= '0;
    end else begin
      case (state_q)
        PWB_INIT: begin
          init_q <= init_q + 1'b1;
          if (init_last) state_q <= PWB_IDLE;
        end
        PWB_IDLE:  if (evt_commit_go) state_q <= PWB_WRITE;
        PWB_WRITE: if (evt_release)   state_q <= PWB_IDLE;
        default:   state_q <= PWB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      page_q <= '0;
      ofs_q  <= '0;
    end else if (evt_open) begin
      open_q <= 1'b1;
      page_q <= wr_addr[ADDR_W-1:OFS_W];
      ofs_q  <= wr_addr[OFS_W-1:0];
    end else if (evt_load) begin
      ofs_q  <= OFS_W'(pwb_wrap_inc(16'(ofs_q), OFS_W));
    end else if (evt_commit) begin
      open_q <= 1'b0;
    end
  end

  assign mem_we    = init_phase || drain_en;
  assign mem_addr  = init_phase ? init_q
                                : ADDR_W'(pwb_join(32'(page_q), 32'(pick_idx), OFS_W));
  assign mem_wdata = init_phase ? ERASED_VAL : pick_data;
  assign busy      = !idle_phase;
endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 6,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wr_phase,
  input logic              evt_commit_go,
  input logic              evt_commit_empty,
  input logic [PAGE_W-1:0] page_q
);
  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R11

  AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit_go |=> (busy && wr_phase)); // R6

  AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit_empty |=> !busy); // R9

  AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_q)); // R7

  AST_ADDR_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase && mem_we && $past(wr_phase) && $past(mem_we)) |-> (mem_addr > $past(mem_addr))); // R5

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase && mem_we && $past(wr_phase) && $past(mem_we))
      |-> (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W]))); // R2
endmodule

bind pwb_ctrl pwb_ctrl_chk #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .busy             (busy),
  .mem_we           (mem_we),
  .mem_addr         (mem_addr),
  .wr_phase         (wr_phase),
  .evt_commit_go    (evt_commit_go),
  .evt_commit_empty (evt_commit_empty),
  .page_q           (page_q)
);

// File: tb/pwb_ctrl_test.sv
module pwb_ctrl_test;
  localparam int PW   = 4;
  localparam int OW   = 6;
  localparam int AW   = PW + OW;
  localparam int SL   = 1 << OW;
  localparam int MEMN = 1 << AW;
  localparam int WRC  = 80;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_open = 1'b0, ld_en = 1'b0, wr_commit = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    ld_data = '0;
  logic          mem_we, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  pwb_ctrl #(.PAGE_W(PW), .OFS_W(OW), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .wr_addr(wr_addr),
    .ld_en(ld_en), .ld_data(ld_data), .wr_commit(wr_commit),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
  );

  int total = 0, bad = 0;
  logic [7:0] obs_mem [MEMN];
  logic [7:0] exp_mem [MEMN];

  // write monitor
  logic          in_init = 1'b1;
  int            init_seen = 0, init_ord_bad = 0, wr_seen = 0, ord_bad = 0;
  logic          prev_wr = 1'b0;
  logic [AW-1:0] last_addr = '0;
  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      obs_mem[mem_addr] <= mem_wdata;
      if (in_init) begin
        if (mem_addr != AW'(init_seen)) init_ord_bad <= init_ord_bad + 1;
        init_seen <= init_seen + 1;
      end else begin
        if (prev_wr && (mem_addr <= last_addr || mem_addr[AW-1:OW] != last_addr[AW-1:OW]))
          ord_bad <= ord_bad + 1;
        wr_seen <= wr_seen + 1;
      end
      last_addr <= mem_addr;
    end
    prev_wr <= rst_n && mem_we && !in_init;
  end

  // reference model
  logic          m_open = 1'b0;
  logic [PW-1:0] m_page = '0;
  logic [OW-1:0] m_ofs = '0;
  logic [7:0]    m_img [SL];
  logic          m_vld [SL];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mem_mismatch();
    int n = 0;
    for (int a = 0; a < MEMN; a++) if (obs_mem[a] !== exp_mem[a]) n++;
    return n;
  endfunction

  task automatic do_start(input logic [AW-1:0] a);
    wr_open = 1'b1; wr_addr = a;
    if (!busy) begin
      m_open = 1'b1; m_page = a[AW-1:OW]; m_ofs = a[OW-1:0];
      for (int i = 0; i < SL; i++) m_vld[i] = 1'b0;
    end
    @(negedge clk); wr_open = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] d);
    ld_en = 1'b1; ld_data = d;
    if (!busy && m_open) begin
      m_img[m_ofs] = d; m_vld[m_ofs] = 1'b1; m_ofs = m_ofs + 1'b1;
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  // commit, then measure busy length, write count and order
  task automatic do_commit(input string tag, input bit poke);
    int nexp = 0, base_w, base_o, cnt = 0;
    bit go = 1'b0;
    base_w = wr_seen; base_o = ord_bad;
    if (!busy && m_open) begin
      for (int i = 0; i < SL; i++) if (m_vld[i]) nexp++;
      go = (nexp > 0);
      if (go)
        for (int i = 0; i < SL; i++)
          if (m_vld[i]) exp_mem[{m_page, OW'(i)}] = m_img[i];
      m_open = 1'b0;
      for (int i = 0; i < SL; i++) m_vld[i] = 1'b0;
    end
    wr_commit = 1'b1;
    @(negedge clk); wr_commit = 1'b0;
    while (busy && cnt < 4 * WRC) begin
      cnt++;
      if (poke && cnt >= 3 && cnt <= 8) begin   // R7 strobes while busy
        wr_open = cnt[0]; wr_addr = AW'($urandom);
        ld_en = !cnt[0]; ld_data = 8'($urandom); wr_commit = (cnt == 8);
      end
      @(negedge clk);
      wr_open = 1'b0; ld_en = 1'b0; wr_commit = 1'b0;
    end
    chk(cnt == (go ? WRC : 0), {tag, " R6 busy length"}, cnt, go ? WRC : 0);
    chk(wr_seen - base_w == nexp, {tag, " R5 write count"}, wr_seen - base_w, nexp);
    chk(ord_bad == base_o, {tag, " R5 order/R2 page"}, ord_bad - base_o, 0);
    chk(mem_mismatch() == 0, {tag, " array image"}, mem_mismatch(), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seed;
    int cnt;
    seed = $urandom(32'h51ab);
    for (int a = 0; a < MEMN; a++) begin exp_mem[a] = 8'hFF; obs_mem[a] = 8'h00; end
    for (int i = 0; i < SL; i++) begin m_img[i] = 8'h00; m_vld[i] = 1'b0; end

    repeat (3) @(negedge clk);
    chk(busy === 1'b1, "R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    cnt = 0;
    while (busy && cnt < 2 * MEMN) begin cnt++; @(negedge clk); end
    in_init = 1'b0;
    chk(cnt == MEMN, "R1 erase sweep length", cnt, MEMN);
    chk(init_seen == MEMN, "R1 erase write count", init_seen, MEMN);
    chk(init_ord_bad == 0, "R1 erase order", init_ord_bad, 0);
    chk(mem_mismatch() == 0, "R1 erased image", mem_mismatch(), 0);

    // R3 R4: start near page end, load past one full wrap
    do_start({PW'(3), OW'(60)});
    for (int i = 0; i < 70; i++) do_load(8'(i + 1));
    do_commit("R3 R4 wrap+overwrite", 1'b0);

    // R9: open then commit with nothing loaded
    do_start({PW'(5), OW'(0)});
    do_commit("R9 empty commit", 1'b0);

    // R10: loads and commit with no open transaction
    for (int i = 0; i < 5; i++) do_load(8'hA5);
    do_commit("R10 no open txn", 1'b0);

    // R5: single byte, neighbours untouched
    do_start({PW'(7), OW'(63)});
    do_load(8'h3C);
    do_commit("R5 single byte", 1'b0);

    // R8: bytes loaded before a restart are discarded
    do_start({PW'(2), OW'(10)});
    for (int i = 0; i < 8; i++) do_load(8'h11);
    do_start({PW'(9), OW'(20)});
    for (int i = 0; i < 4; i++) do_load(8'h22 + 8'(i));
    do_commit("R8 restart", 1'b0);

    // R7: strobes during busy, then a commit with no new start
    do_start({PW'(1), OW'(5)});
    for (int i = 0; i < 12; i++) do_load(8'(8'h40 + i));
    do_commit("R7 busy poke", 1'b1);
    do_commit("R7 after poke", 1'b0);

    // random transactions
    for (int t = 0; t < 30; t++) begin
      int n;
      n = $urandom_range(0, 140);
      do_start(AW'($urandom));
      if ($urandom_range(0, 4) == 0) begin
        for (int i = 0; i < 6; i++) do_load(8'($urandom));
        do_start(AW'($urandom));   // R8
      end
      for (int i = 0; i < n; i++) do_load(8'($urandom));
      do_commit("R2 R5 random", (t % 4) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule